// File: doc/BRIEF.md
# IOMMU Translation Cache with Tagged Invalidation

This block is a small, fully associative cache of address translations for an I/O memory management unit. Each entry holds an output page number. The entry is tagged with three fields: an address-space identifier (ASID), a virtual-machine identifier (VMID) and an input page number. A client presents a lookup with all three tags. One cycle later it gets a response that says hit or miss and, on a hit, carries the translation. A separate port writes new translations into the cache. A miss returns zero in place of the translation.

A third port removes cached translations. It has four kinds of request: drop everything, drop by ASID, drop by VMID, and drop a range of pages that belong to one ASID and VMID pair. The range is given by a base page, a granule code and a page count. Every invalidation completes in the cycle it is issued. All affected valid bits are cleared at once. The block also keeps running totals of the hits and misses reported by lookups.

Top module: `iotlb_cache`

## Requirements
- R1: After synchronous reset, every entry is invalid, both counters read zero and `rsp_valid` is low. So the first lookup after reset misses.
- R2: A lookup sampled at a clock edge is answered at that same edge: `rsp_valid` rises and the result is visible in the following cycle. It hits only when one valid entry matches the ASID, VMID and page number all together. A hit returns that entry's output page. A miss returns zero. The lookup sees the contents as they were before any fill or invalidation sampled at the same edge.
- R3: A fill whose three tags equal those of a valid entry overwrites that entry. Otherwise it takes the lowest-numbered invalid entry. If every entry is valid, it takes the entry at the round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping after the last entry, only when it was used.
- R4: An invalidation of kind 2'b00 clears every entry.
- R5: An invalidation of kind 2'b01 clears every entry whose ASID equals the request's ASID, for any VMID or page.
- R6: An invalidation of kind 2'b10 clears every entry whose VMID equals the request's VMID, for any ASID or page.
- R7: An invalidation of kind 2'b11 clears the entries whose ASID and VMID both match and whose page lies in a range. The range starts at the request page aligned down to the granule. It spans (count field + 1) granules. Granule code 0 is one base page, code 1 is 4 base pages, and codes 2 and 3 are 16 base pages.
- R8: The level hint carried by a range invalidation has no effect on which entries are cleared.
- R9: When an invalidation and a fill are sampled at the same edge, the fill is discarded. No entry is written and the round-robin pointer does not move.
- R10: Each lookup response adds one to the hit counter or to the miss counter, according to its result, in the same cycle that the response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup ASID |
| lk_vmid | input | VMID_W | Lookup VMID |
| lk_vpn | input | VPN_W | Lookup input page number |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_ppn | output | PPN_W | Output page on hit, zero on miss |
| fill_valid | input | 1 | Fill request |
| fill_asid | input | ASID_W | Fill ASID tag |
| fill_vmid | input | VMID_W | Fill VMID tag |
| fill_vpn | input | VPN_W | Fill input page tag |
| fill_ppn | input | PPN_W | Fill output page |
| inv_valid | input | 1 | Invalidation request |
| inv_kind | input | 2 | 00 all, 01 by ASID, 10 by VMID, 11 page range |
| inv_asid | input | ASID_W | ASID operand |
| inv_vmid | input | VMID_W | VMID operand |
| inv_vpn | input | VPN_W | Range base page |
| inv_gran | input | 2 | Range granule code |
| inv_pages | input | PAGES_W | Range granule count minus one |
| inv_ttl | input | TTL_W | Level hint (no effect) |
| hit_count | output | CNT_W | Running hit total |
| miss_count | output | CNT_W | Running miss total |

## Verification
The bench builds the cache with 4 entries, 4-bit ASID and VMID, 12-bit page numbers and a 4-bit count field. Random fills drawn from three ASIDs, three VMIDs and a couple of dozen pages keep the cache full most of the time. That drives the round-robin pointer through many wraps, and it puts same-tag overwrites, partial ID matches and range edges in reach on most invalidations. The short count field and 16-page granule let a range request cover anything from a single page to most of the page space the stimulus uses.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    typedef enum logic [1:0] {
        INV_ALL   = 2'b00,
        INV_ASID  = 2'b01,
        INV_VMID  = 2'b10,
        INV_RANGE = 2'b11
    } inv_kind_e;

    // log2 of the number of base pages in one granule
    function automatic logic [2:0] gran_shift(input logic [1:0] code);
        case (code)
            2'd0:    gran_shift = 3'd0;
            2'd1:    gran_shift = 3'd2;
            default: gran_shift = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/iotlb_match.sv
module iotlb_match
    import iotlb_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned ASID_W      = 16,
    parameter int unsigned VMID_W      = 16,
    parameter int unsigned VPN_W       = 20,
    parameter int unsigned PPN_W       = 20,
    parameter int unsigned PAGES_W     = 8
) (
    input  logic [NUM_ENTRIES-1:0] e_valid,
    input  logic [ASID_W-1:0]      e_asid [NUM_ENTRIES],
    input  logic [VMID_W-1:0]      e_vmid [NUM_ENTRIES],
    input  logic [VPN_W-1:0]       e_vpn  [NUM_ENTRIES],
    input  logic [PPN_W-1:0]       e_ppn  [NUM_ENTRIES],
    input  logic [ASID_W-1:0]      lk_asid,
    input  logic [VMID_W-1:0]      lk_vmid,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [ASID_W-1:0]      fill_asid,
    input  logic [VMID_W-1:0]      fill_vmid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [1:0]             inv_kind,
    input  logic [ASID_W-1:0]      inv_asid,
    input  logic [VMID_W-1:0]      inv_vmid,
    input  logic [VPN_W-1:0]       inv_vpn,
    input  logic [1:0]             inv_gran,
    input  logic [PAGES_W-1:0]     inv_pages,
    output logic [NUM_ENTRIES-1:0] lk_hit_vec,
    output logic [PPN_W-1:0]       lk_ppn,
    output logic [NUM_ENTRIES-1:0] same_vec,
    output logic [NUM_ENTRIES-1:0] kill_vec
);
    localparam int unsigned EXT_W = VPN_W + PAGES_W + 6;

    logic [2:0]       shf;
    logic [EXT_W-1:0] gran_mask;
    logic [EXT_W-1:0] base_al;
    logic [EXT_W-1:0] span;
    logic [EXT_W-1:0] end_ex;

    always_comb begin
        shf       = gran_shift(inv_gran);
        gran_mask = (EXT_W'(1) << shf) - EXT_W'(1);
        base_al   = EXT_W'(inv_vpn) & ~gran_mask;
        span      = (EXT_W'(inv_pages) + EXT_W'(1)) << shf;
        end_ex    = base_al + span;
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        logic ids_hit;
        logic in_rng;
        assign lk_hit_vec[i] = e_valid[i] && (e_asid[i] == lk_asid)
                             && (e_vmid[i] == lk_vmid) && (e_vpn[i] == lk_vpn);
        assign same_vec[i]   = e_valid[i] && (e_asid[i] == fill_asid)
                             && (e_vmid[i] == fill_vmid) && (e_vpn[i] == fill_vpn);
        assign ids_hit       = (e_asid[i] == inv_asid) && (e_vmid[i] == inv_vmid);
        assign in_rng        = (EXT_W'(e_vpn[i]) >= base_al) && (EXT_W'(e_vpn[i]) < end_ex);

        always_comb begin
            case (inv_kind_e'(inv_kind))
                INV_ALL:   kill_vec[i] = 1'b1;
                INV_ASID:  kill_vec[i] = e_asid[i] == inv_asid;
                INV_VMID:  kill_vec[i] = e_vmid[i] == inv_vmid;
                default:   kill_vec[i] = ids_hit && in_rng;
            endcase
        end
    end

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (lk_hit_vec[i]) lk_ppn = lk_ppn | e_ppn[i];
        end
    end

endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned IDX_W       = 4
) (
    input  logic [NUM_ENTRIES-1:0] valid_vec,
    input  logic [NUM_ENTRIES-1:0] same_vec,
    input  logic [IDX_W-1:0]       rr_ptr,
    output logic [IDX_W-1:0]       victim,
    output logic                   use_rr
);
    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic [IDX_W-1:0] same_idx;
    logic             same_any;

    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        same_idx = '0;
        same_any = 1'b0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
            if (same_vec[i]) begin
                same_idx = IDX_W'(i);
                same_any = 1'b1;
            end
        end
        use_rr = 1'b0;
        if (same_any)      victim = same_idx;
        else if (free_any) victim = free_idx;
        else begin
            victim = rr_ptr;
            use_rr = 1'b1;
        end
    end

endmodule

// File: rtl/iotlb_resp.sv
module iotlb_resp #(
    parameter int unsigned PPN_W = 20,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic             lk_hit,
    input  logic [PPN_W-1:0] lk_ppn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_ppn    <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_hit;
            rsp_ppn   <= (lk_valid && lk_hit) ? lk_ppn : '0;
            if (lk_valid) begin
                if (lk_hit) hit_count  <= hit_count + CNT_W'(1);
                else        miss_count <= miss_count + CNT_W'(1);
            end
        end
    end

    // R10
    hit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (hit_count == $past(hit_count) + CNT_W'(1)));

    // R10
    miss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (miss_count == $past(miss_count) + CNT_W'(1)));

    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0));

endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
    import iotlb_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned ASID_W      = 16,
    parameter int unsigned VMID_W      = 16,
    parameter int unsigned VPN_W       = 20,
    parameter int unsigned PPN_W       = 20,
    parameter int unsigned PAGES_W     = 8,
    parameter int unsigned TTL_W       = 2,
    parameter int unsigned CNT_W       = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic [VMID_W-1:0]  lk_vmid,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [PPN_W-1:0]   rsp_ppn,
    input  logic               fill_valid,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [VMID_W-1:0]  fill_vmid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic               inv_valid,
    input  logic [1:0]         inv_kind,
    input  logic [ASID_W-1:0]  inv_asid,
    input  logic [VMID_W-1:0]  inv_vmid,
    input  logic [VPN_W-1:0]   inv_vpn,
    input  logic [1:0]         inv_gran,
    input  logic [PAGES_W-1:0] inv_pages,
    input  logic [TTL_W-1:0]   inv_ttl,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count
);
    localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    logic [NUM_ENTRIES-1:0] e_valid;
    logic [ASID_W-1:0]      e_asid [NUM_ENTRIES];
    logic [VMID_W-1:0]      e_vmid [NUM_ENTRIES];
    logic [VPN_W-1:0]       e_vpn  [NUM_ENTRIES];
    logic [PPN_W-1:0]       e_ppn  [NUM_ENTRIES];
    logic [IDX_W-1:0]       rr_ptr;

    logic [NUM_ENTRIES-1:0] lk_hit_vec;
    logic [NUM_ENTRIES-1:0] same_vec;
    logic [NUM_ENTRIES-1:0] kill_vec;
    logic [PPN_W-1:0]       lk_ppn;
    logic [IDX_W-1:0]       victim;
    logic                   use_rr;
    logic                   do_fill;
    logic                   ttl_unused;

    assign ttl_unused = ^inv_ttl;
    assign do_fill    = fill_valid && !inv_valid;

    iotlb_match #(
        .NUM_ENTRIES(NUM_ENTRIES), .ASID_W(ASID_W), .VMID_W(VMID_W),
        .VPN_W(VPN_W), .PPN_W(PPN_W), .PAGES_W(PAGES_W)
    ) u_match (
        .e_valid(e_valid), .e_asid(e_asid), .e_vmid(e_vmid),
        .e_vpn(e_vpn), .e_ppn(e_ppn),
        .lk_asid(lk_asid), .lk_vmid(lk_vmid), .lk_vpn(lk_vpn),
        .fill_asid(fill_asid), .fill_vmid(fill_vmid), .fill_vpn(fill_vpn),
        .inv_kind(inv_kind), .inv_asid(inv_asid), .inv_vmid(inv_vmid),
        .inv_vpn(inv_vpn), .inv_gran(inv_gran), .inv_pages(inv_pages),
        .lk_hit_vec(lk_hit_vec), .lk_ppn(lk_ppn),
        .same_vec(same_vec), .kill_vec(kill_vec)
    );

    iotlb_victim #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid_vec(e_valid), .same_vec(same_vec), .rr_ptr(rr_ptr),
        .victim(victim), .use_rr(use_rr)
    );

    iotlb_resp #(.PPN_W(PPN_W), .CNT_W(CNT_W)) u_resp (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_hit(|lk_hit_vec),
        .lk_ppn(lk_ppn), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_ppn(rsp_ppn), .hit_count(hit_count), .miss_count(miss_count)
    );

    // valid bits and replacement pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            e_valid <= '0;
            rr_ptr  <= '0;
        end else if (inv_valid) begin
            e_valid <= e_valid & ~kill_vec;
        end else if (do_fill) begin
            e_valid[victim] <= 1'b1;
            if (use_rr) rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + IDX_W'(1);
        end
    end

    // tag and data storage, qualified by the valid bits
    always_ff @(posedge clk) begin
        if (do_fill) begin
            e_asid[victim] <= fill_asid;
            e_vmid[victim] <= fill_vmid;
            e_vpn[victim]  <= fill_vpn;
            e_ppn[victim]  <= fill_ppn;
        end
    end

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_vec));

    // R4
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && inv_kind == 2'b00) |=> (e_valid == '0));

    // R9
    inv_over_fill_chk: assert property (@(posedge clk) disable iff (rst)
        inv_valid |=> ($countones(e_valid) <= $past($countones(e_valid))));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        inv_valid |=> $stable(rr_ptr));

    // R3
    fill_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !inv_valid) |=> (e_valid != '0));

endmodule

// File: tb/iotlb_cache_bench.sv
module iotlb_cache_bench;
    localparam int N   = 4;
    localparam int AW  = 4;
    localparam int VW  = 4;
    localparam int PW  = 12;
    localparam int OW  = 12;
    localparam int CW  = 4;
    localparam int TW  = 2;
    localparam int NW  = 16;

    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    logic          lk_valid, fill_valid, inv_valid;
    logic [AW-1:0] lk_asid, fill_asid, inv_asid;
    logic [VW-1:0] lk_vmid, fill_vmid, inv_vmid;
    logic [PW-1:0] lk_vpn, fill_vpn, inv_vpn;
    logic [OW-1:0] fill_ppn;
    logic [1:0]    inv_kind, inv_gran;
    logic [CW-1:0] inv_pages;
    logic [TW-1:0] inv_ttl;
    logic          rsp_valid, rsp_hit;
    logic [OW-1:0] rsp_ppn;
    logic [NW-1:0] hit_count, miss_count;

    iotlb_cache #(
        .NUM_ENTRIES(N), .ASID_W(AW), .VMID_W(VW), .VPN_W(PW), .PPN_W(OW),
        .PAGES_W(CW), .TTL_W(TW), .CNT_W(NW)
    ) u_iotlb_cache (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vmid(lk_vmid), .lk_vpn(lk_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vmid(fill_vmid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_asid(inv_asid),
        .inv_vmid(inv_vmid), .inv_vpn(inv_vpn), .inv_gran(inv_gran),
        .inv_pages(inv_pages), .inv_ttl(inv_ttl),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // reference state
    bit      m_v    [N];
    int      m_asid [N];
    int      m_vmid [N];
    int      m_vpn  [N];
    int      m_ppn  [N];
    int      m_ptr;
    int      m_hits, m_miss;
    int      n_chk, n_fail;
    bit      done;
    string   tag;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int shift_of(input int g);
        return (g == 0) ? 0 : (g == 1) ? 2 : 4;
    endfunction

    function automatic bit kills(input int i, input int kind, input int a,
                                 input int v, input int p, input int g, input int n);
        int sh, base, lim;
        sh   = shift_of(g);
        base = (p >> sh) << sh;
        lim  = base + ((n + 1) << sh);
        case (kind)
            0: return 1'b1;
            1: return m_asid[i] == a;
            2: return m_vmid[i] == v;
            default: return (m_asid[i] == a) && (m_vmid[i] == v)
                            && (m_vpn[i] >= base) && (m_vpn[i] < lim);
        endcase
    endfunction

    task automatic idle();
        lk_valid = 0; fill_valid = 0; inv_valid = 0;
        lk_asid = '0; lk_vmid = '0; lk_vpn = '0;
        fill_asid = '0; fill_vmid = '0; fill_vpn = '0; fill_ppn = '0;
        inv_kind = '0; inv_asid = '0; inv_vmid = '0; inv_vpn = '0;
        inv_gran = '0; inv_pages = '0; inv_ttl = '0;
    endtask

    // one clock: predict from pre-edge state, apply edge, check, update model
    task automatic step();
        bit e_hit;
        int e_ppn;
        bit was_lk;
        e_hit  = 0;
        e_ppn  = 0;
        was_lk = lk_valid;
        if (lk_valid)
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_asid[i] == int'(lk_asid) && m_vmid[i] == int'(lk_vmid)
                    && m_vpn[i] == int'(lk_vpn)) begin
                    e_hit = 1;
                    e_ppn = m_ppn[i];
                end
        if (inv_valid) begin
            for (int i = 0; i < N; i++)
                if (kills(i, int'(inv_kind), int'(inv_asid), int'(inv_vmid),
                          int'(inv_vpn), int'(inv_gran), int'(inv_pages)))
                    m_v[i] = 0;
        end else if (fill_valid) begin
            int slot;
            slot = -1;
            for (int i = N - 1; i >= 0; i--)
                if (!m_v[i]) slot = i;
            for (int i = N - 1; i >= 0; i--)
                if (m_v[i] && m_asid[i] == int'(fill_asid) && m_vmid[i] == int'(fill_vmid)
                    && m_vpn[i] == int'(fill_vpn)) slot = i;
            if (slot < 0) begin
                slot  = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_v[slot]    = 1;
            m_asid[slot] = int'(fill_asid);
            m_vmid[slot] = int'(fill_vmid);
            m_vpn[slot]  = int'(fill_vpn);
            m_ppn[slot]  = int'(fill_ppn);
        end
        if (was_lk) begin
            if (e_hit) m_hits++;
            else       m_miss++;
        end
        @(posedge clk);
        #1;
        if (was_lk) begin
            chk(rsp_valid == 1'b1, tag, "rsp_valid", rsp_valid, 1);
            chk(rsp_hit == e_hit, tag, "rsp_hit", rsp_hit, e_hit);
            chk(int'(rsp_ppn) == e_ppn, tag, "rsp_ppn", rsp_ppn, e_ppn);
            // R10
            chk(int'(hit_count) == (m_hits % 65536) && int'(miss_count) == (m_miss % 65536),
                "R10", "hit+miss counters", {hit_count, miss_count},
                {m_hits[15:0], m_miss[15:0]});
        end
        @(negedge clk);
        idle();
    endtask

    task automatic fill(input int a, input int v, input int p, input int o);
        fill_valid = 1; fill_asid = AW'(a); fill_vmid = VW'(v);
        fill_vpn = PW'(p); fill_ppn = OW'(o);
        step();
    endtask

    task automatic look(input int a, input int v, input int p);
        lk_valid = 1; lk_asid = AW'(a); lk_vmid = VW'(v); lk_vpn = PW'(p);
        step();
    endtask

    task automatic inval(input int k, input int a, input int v, input int p,
                         input int g, input int n, input int t);
        inv_valid = 1; inv_kind = 2'(k); inv_asid = AW'(a); inv_vmid = VW'(v);
        inv_vpn = PW'(p); inv_gran = 2'(g); inv_pages = CW'(n); inv_ttl = TW'(t);
        step();
    endtask

    task automatic probe_all();
        for (int i = 0; i < N; i++)
            if (m_v[i]) look(m_asid[i], m_vmid[i], m_vpn[i]);
    endtask

    task automatic load4(input int base);
        fill(1, 1, base, 100 + base);
        fill(1, 2, base + 1, 101 + base);
        fill(2, 1, base + 2, 102 + base);
        fill(2, 2, base + 3, 103 + base);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7431));
        idle();
        rst = 1;
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_ptr = 0; m_hits = 0; m_miss = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1
        chk(rsp_valid == 0 && hit_count == 0 && miss_count == 0, "R1", "reset outputs",
            {rsp_valid, hit_count, miss_count}, 0);
        tag = "R1";
        look(1, 1, 5);

        tag = "R2";
        load4(10);
        probe_all();
        look(1, 1, 11);          // wrong VMID for page 11
        look(3, 1, 10);          // unknown ASID
        // lookup and same-cycle invalidate still sees old contents
        lk_valid = 1; lk_asid = 1; lk_vmid = 1; lk_vpn = 10;
        inv_valid = 1; inv_kind = 2'b00;
        step();
        look(1, 1, 10);

        tag = "R3";
        load4(20);
        fill(3, 3, 30, 300);     // full: replaces slot at pointer 0
        look(1, 1, 20);
        look(3, 3, 30);
        fill(1, 2, 21, 555);     // same tags: overwrite in place
        look(1, 2, 21);
        fill(3, 3, 31, 301);     // pointer now 1
        probe_all();

        tag = "R9";
        fill_valid = 1; fill_asid = 2; fill_vmid = 3; fill_vpn = 40; fill_ppn = 77;
        inv_valid = 1; inv_kind = 2'b01; inv_asid = 9;
        step();
        look(2, 3, 40);
        fill(2, 3, 41, 78);      // pointer unchanged by discarded fill
        probe_all();

        tag = "R4";
        inval(0, 0, 0, 0, 0, 0, 0);
        look(3, 3, 30);
        look(2, 3, 41);

        tag = "R5";
        load4(50);
        inval(1, 1, 0, 0, 0, 0, 0);
        look(1, 1, 50);
        look(1, 2, 51);
        probe_all();

        tag = "R6";
        inval(0, 0, 0, 0, 0, 0, 0);
        load4(60);
        inval(2, 0, 2, 0, 0, 0, 0);
        look(1, 2, 61);
        probe_all();

        tag = "R7";
        inval(0, 0, 0, 0, 0, 0, 0);
        fill(1, 1, 64, 1); fill(1, 1, 67, 2); fill(1, 1, 68, 3); fill(1, 2, 65, 4);
        inval(3, 1, 1, 66, 1, 0, 0);   // granule 4 pages: 64..67
        look(1, 1, 64); look(1, 1, 67); look(1, 1, 68); look(1, 2, 65);
        inval(3, 1, 1, 68, 0, 0, 0);   // single page 68
        look(1, 1, 68);
        fill(1, 1, 79, 5); fill(1, 1, 80, 6);
        inval(3, 1, 1, 70, 2, 0, 0);   // 16 pages: 64..79
        look(1, 1, 79); look(1, 1, 80);
        fill(1, 1, 96, 7); fill(1, 1, 127, 8);
        inval(3, 1, 1, 100, 3, 1, 0);  // code 3, two granules: 96..127
        look(1, 1, 96); look(1, 1, 127); look(1, 1, 80);

        tag = "R8";
        inval(0, 0, 0, 0, 0, 0, 0);
        fill(2, 2, 8, 11); fill(2, 2, 9, 12); fill(2, 2, 12, 13);
        inval(3, 2, 2, 8, 0, 0, 3);
        look(2, 2, 8); look(2, 2, 9);
        inval(3, 2, 2, 9, 1, 0, 1);
        look(2, 2, 9); look(2, 2, 12);

        // mixed random traffic
        for (int c = 0; c < 4000; c++) begin
            tag = "R2";
            if ($urandom % 10 < 7) begin
                lk_valid = 1; lk_asid = AW'($urandom % 3); lk_vmid = VW'($urandom % 3);
                lk_vpn = PW'($urandom % 24);
            end
            if ($urandom % 10 < 4) begin
                fill_valid = 1; fill_asid = AW'($urandom % 3); fill_vmid = VW'($urandom % 3);
                fill_vpn = PW'($urandom % 24); fill_ppn = OW'($urandom);
            end
            if ($urandom % 12 == 0) begin
                inv_valid = 1; inv_kind = 2'($urandom); inv_asid = AW'($urandom % 3);
                inv_vmid = VW'($urandom % 3); inv_vpn = PW'($urandom % 24);
                inv_gran = 2'($urandom); inv_pages = CW'($urandom % 3); inv_ttl = TW'($urandom);
            end
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule